// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block drives a three-wire serial control bus that programs the registers of an audio codec. The bus has a clock line, a data line that can be driven either way, and a mode line. A host starts a transaction with a one-cycle `start` pulse. With the pulse it gives a 6-bit device address, a 2-bit register-type selector, the direction, and whether one or two data bytes follow. The block then runs the whole transaction by itself. It sends an address byte and then moves each data byte one bit at a time. Every interval is a parameter counted in system clocks: clock low, clock high, setup before a byte, hold after a byte, and the halt gap before the second data byte.

Each pad has its own output-enable, so the pads can be tri-stated. While the bus is idle, all three lines are released to inputs. When a transaction begins they are driven high. On a read, the data line is released after the address byte so the codec can answer. `busy` stays high for the whole transaction. `done` pulses once at the end. Read bytes appear on `rdata0` and `rdata1`.

Top module: `ctl3w_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `sclk_oe`, `sdat_oe` and `smode_oe` are all 0, and `busy` and `done` are 0.
- R2: A `start` pulse seen while idle makes `busy` high from the next cycle. In that first busy cycle, all three lines are driven (oe = 1) at level 1. The mode line stays driven at 1 for as long as `busy` is high.
- R3: The first byte on the bus is the address byte. Its bits 7:2 are `dev_addr` and its bits 1:0 are `reg_sel`. Every byte goes out least significant bit first, and each bit is taken by the receiver on a rising edge of `sclk_o`.
- R4: On a write, the first data byte is `wdata0` and the second is `wdata1`. Each bit is placed while the clock is low. The clock stays low LOW_CYC cycles per bit and high HIGH_CYC cycles per bit. While `sdat_oe` is 1, `sdat_o` never changes while the clock is high.
- R5: On a read, `sdat_oe` drops to 0 at the end of the address byte and stays 0 until the end of the transaction. `sdat_i` is sampled on the clock edge that ends each clock-low interval. Bits are assembled least significant bit first into `rdata0` (first data byte) and `rdata1` (second data byte).
- R6: No halt comes before the first data byte. Before the second data byte, the clock is held low for HALT_CYC cycles and then raised. A one-data-byte transaction therefore has 16 falling clock edges, and a two-data-byte transaction has 25.
- R7: `busy` stays high for exactly 1 + n*(SETUP_CYC + 8*(LOW_CYC + HIGH_CYC) + HOLD_CYC) cycles, plus HALT_CYC when two data bytes are moved. Here n = 2 for one data byte and n = 3 for two (the address byte counts).
- R8: `done` is high for exactly one cycle: the first cycle in which `busy` is low again. In that same cycle all three lines are released.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running transaction finishes with the fields latched when it was accepted, and no new transaction follows.
- R10: When a transaction is accepted, `rdata0` and `rdata1` are cleared to 0. A read of one data byte leaves `rdata1` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle transaction request |
| dev_addr | input | 6 | Device address, goes to address-byte bits 7:2 |
| reg_sel | input | 2 | Register-type selector, goes to address-byte bits 1:0 |
| two_bytes | input | 1 | 1: two data bytes, 0: one data byte |
| read_en | input | 1 | 1: read, 0: write |
| wdata0 | input | 8 | First data byte to write |
| wdata1 | input | 8 | Second data byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata0 | output | 8 | First byte read |
| rdata1 | output | 8 | Second byte read |
| sclk_o | output | 1 | Bus clock level |
| sclk_oe | output | 1 | Bus clock pad output-enable |
| sdat_o | output | 1 | Bus data level when driven |
| sdat_oe | output | 1 | Bus data pad output-enable |
| sdat_i | input | 1 | Bus data level from the pad |
| smode_o | output | 1 | Mode line level |
| smode_oe | output | 1 | Mode line pad output-enable |

## Verification
The hardest case to reach is a two-byte read. There the data line must turn around after the address byte, and the responder must answer across the halt gap. The halt adds a falling clock edge that carries no bit. The bench models the codec: on each falling clock edge seen while the data line is released, it drives the next response bit. It skips the halt's falling edge, so a wrong halt position or a wrong sample point shows up as a wrong `rdata1`. Mid-transaction `start` pulses that carry inverted fields exercise the ignore rule. Any late latch would then show up in the bits on the bus, the busy length or the read bytes.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SETUP,
    ST_BLO,
    ST_BHI,
    ST_HOLD,
    ST_HALT
  } c3_state_t;

  // largest of the five interval parameters, sizes the shared counter
  function automatic int c3_max5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // address byte: device field above the selector field
  function automatic logic [7:0] c3_addr_byte(input logic [5:0] dev,
                                              input logic [1:0] sel);
    return {dev, sel};
  endfunction

  // busy length of one transaction in system clocks
  function automatic int unsigned c3_txn_cycles(input logic two, input int s,
                                                input int lo, input int hi,
                                                input int hd, input int ha,
                                                input int bits);
    int unsigned nb;
    int unsigned per;
    nb  = two ? 3 : 2;
    per = s + bits * (lo + hi) + hd;
    return 1 + nb * per + (two ? ha : 0);
  endfunction

endpackage

// File: rtl/ctl3w_timer.sv
module ctl3w_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // a load of N makes expired high in the Nth cycle after the load edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sample,
  input  logic         din,
  output logic         tx_bit,
  output logic [W-1:0] rx_byte
);

  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  // transmit side: the low bit is presented first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_val;
    end else if (shift) begin
      tx_q <= {1'b0, tx_q[W-1:1]};
    end
  end

  // receive side: each new bit enters at the top, so the first one ends at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {din, rx_q[W-1:1]};
    end
  end

  assign tx_bit  = tx_q[0];
  assign rx_byte = rx_q;

endmodule

// File: rtl/ctl3w_master.sv
module ctl3w_master
  import ctl3w_pkg::*;
#(
  parameter int DEV_W     = 6,
  parameter int SEL_W     = 2,
  parameter int LOW_CYC   = 8,
  parameter int HIGH_CYC  = 8,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 4,
  parameter int HALT_CYC  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [DEV_W-1:0]       dev_addr,
  input  logic [SEL_W-1:0]       reg_sel,
  input  logic                   two_bytes,
  input  logic                   read_en,
  input  logic [DEV_W+SEL_W-1:0] wdata0,
  input  logic [DEV_W+SEL_W-1:0] wdata1,
  output logic                   busy,
  output logic                   done,
  output logic [DEV_W+SEL_W-1:0] rdata0,
  output logic [DEV_W+SEL_W-1:0] rdata1,
  output logic                   sclk_o,
  output logic                   sclk_oe,
  output logic                   sdat_o,
  output logic                   sdat_oe,
  input  logic                   sdat_i,
  output logic                   smode_o,
  output logic                   smode_oe
);

  localparam int BYTE_W = DEV_W + SEL_W;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int TMAX   = c3_max5(LOW_CYC, HIGH_CYC, SETUP_CYC, HOLD_CYC, HALT_CYC);
  localparam int CNT_W  = $clog2(TMAX + 1);

  // ---------------- request latched at acceptance ----------------
  logic [BYTE_W-1:0] addr_q, w0_q, w1_q;
  logic              two_q, rd_q;

  // ---------------- sequencer state ----------------
  c3_state_t         st_q, st_d;
  logic [1:0]        byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, done_q;
  logic              sclk_q, sdat_q, mode_q;
  logic              ln_oe_q, dat_oe_q;
  logic [BYTE_W-1:0] rd0_q, rd1_q;

  // ---------------- named internal events ----------------
  logic              accept;
  logic              tm_exp;
  logic              bit_last;
  logic              byte_last;
  logic              in_data;
  logic              tm_load;
  logic [CNT_W-1:0]  tm_val;
  logic              sh_load, sh_shift, sh_sample;
  logic [BYTE_W-1:0] sh_val;
  logic              tx_bit;
  logic [BYTE_W-1:0] rx_byte;

  assign accept    = start && !busy_q;
  assign bit_last  = (bit_q == BIT_W'(BYTE_W - 1));
  assign byte_last = (byte_q == (two_q ? 2'd2 : 2'd1));
  assign in_data   = (byte_q != 2'd0);
  assign sh_val    = (st_q == ST_START) ? addr_q : (byte_q == 2'd0 ? w0_q : w1_q);

  ctl3w_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  ctl3w_shifter #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .sample   (sh_sample),
    .din      (sdat_i),
    .tx_bit   (tx_bit),
    .rx_byte  (rx_byte)
  );

  // ---------------- next state, timer loads, shifter controls ----------------
  always_comb begin
    st_d      = st_q;
    tm_load   = 1'b0;
    tm_val    = CNT_W'(1);
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_sample = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_START;
          tm_load = 1'b1;
          tm_val  = CNT_W'(1);
        end
      end
      ST_START: begin
        if (tm_exp) begin
          st_d    = ST_SETUP;
          tm_load = 1'b1;
          tm_val  = CNT_W'(SETUP_CYC);
          sh_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tm_exp) begin
          st_d     = ST_BLO;
          tm_load  = 1'b1;
          tm_val   = CNT_W'(LOW_CYC);
          sh_shift = 1'b1;
        end
      end
      ST_BLO: begin
        if (tm_exp) begin
          st_d      = ST_BHI;
          tm_load   = 1'b1;
          tm_val    = CNT_W'(HIGH_CYC);
          sh_sample = rd_q && in_data;
        end
      end
      ST_BHI: begin
        if (tm_exp) begin
          tm_load = 1'b1;
          if (bit_last) begin
            st_d   = ST_HOLD;
            tm_val = CNT_W'(HOLD_CYC);
          end else begin
            st_d     = ST_BLO;
            tm_val   = CNT_W'(LOW_CYC);
            sh_shift = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tm_exp) begin
          if (byte_last) begin
            st_d = ST_IDLE;
          end else if (byte_q == 2'd1) begin
            st_d    = ST_HALT;
            tm_load = 1'b1;
            tm_val  = CNT_W'(HALT_CYC);
          end else begin
            st_d    = ST_SETUP;
            tm_load = 1'b1;
            tm_val  = CNT_W'(SETUP_CYC);
            sh_load = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (tm_exp) begin
          st_d    = ST_SETUP;
          tm_load = 1'b1;
          tm_val  = CNT_W'(SETUP_CYC);
          sh_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- registered bus lines and counters ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b1;
      sdat_q   <= 1'b1;
      mode_q   <= 1'b0;
      ln_oe_q  <= 1'b0;
      dat_oe_q <= 1'b0;
      byte_q   <= 2'd0;
      bit_q    <= '0;
      addr_q   <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      two_q    <= 1'b0;
      rd_q     <= 1'b0;
      rd0_q    <= '0;
      rd1_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q   <= c3_addr_byte(dev_addr, reg_sel);
            w0_q     <= wdata0;
            w1_q     <= wdata1;
            two_q    <= two_bytes;
            rd_q     <= read_en;
            busy_q   <= 1'b1;
            ln_oe_q  <= 1'b1;
            dat_oe_q <= 1'b1;
            mode_q   <= 1'b1;
            sclk_q   <= 1'b1;
            sdat_q   <= 1'b1;
            byte_q   <= 2'd0;
            bit_q    <= '0;
            rd0_q    <= '0;
            rd1_q    <= '0;
          end
        end
        ST_START: begin
          if (tm_exp) sclk_q <= 1'b0;          // clock pulled low ahead of the address byte
        end
        ST_SETUP: begin
          if (tm_exp) begin
            sclk_q <= 1'b0;
            sdat_q <= tx_bit;
          end
        end
        ST_BLO: begin
          if (tm_exp) sclk_q <= 1'b1;
        end
        ST_BHI: begin
          if (tm_exp) begin
            if (bit_last) begin
              bit_q <= '0;
              if (rd_q && byte_q == 2'd1) rd0_q <= rx_byte;
              if (rd_q && byte_q == 2'd2) rd1_q <= rx_byte;
            end else begin
              bit_q  <= bit_q + BIT_W'(1);
              sclk_q <= 1'b0;
              sdat_q <= tx_bit;
            end
          end
        end
        ST_HOLD: begin
          if (tm_exp) begin
            if (byte_last) begin
              busy_q   <= 1'b0;
              done_q   <= 1'b1;
              ln_oe_q  <= 1'b0;
              dat_oe_q <= 1'b0;
              mode_q   <= 1'b0;
              byte_q   <= 2'd0;
            end else begin
              byte_q <= byte_q + 2'd1;
              if (rd_q && byte_q == 2'd0) dat_oe_q <= 1'b0;   // turnaround
              if (byte_q == 2'd1) sclk_q <= 1'b0;             // halt gap
            end
          end
        end
        ST_HALT: begin
          if (tm_exp) sclk_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata0   = rd0_q;
  assign rdata1   = rd1_q;
  assign sclk_o   = sclk_q;
  assign sclk_oe  = ln_oe_q;
  assign sdat_o   = sdat_q;
  assign sdat_oe  = dat_oe_q;
  assign smode_o  = mode_q;
  assign smode_oe = ln_oe_q;

  // ---------------- checks next to the logic ----------------
  logic [31:0] busy_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt_q <= '0;
    else if (accept) busy_cnt_q <= '0;
    else if (busy_q) busy_cnt_q <= busy_cnt_q + 32'd1;
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!sclk_oe && !sdat_oe && !smode_oe));

  p_mode_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (smode_oe && smode_o));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o) && sdat_oe && $past(sdat_oe)) |-> $stable(sdat_o));

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && in_data) |-> !sdat_oe);

  p_halt_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |-> (byte_q == 2'd2 && two_q));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (busy_cnt_q == c3_txn_cycles(two_q, SETUP_CYC, LOW_CYC, HIGH_CYC,
                                            HOLD_CYC, HALT_CYC, BYTE_W)));

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q) && !sclk_oe && !sdat_oe));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_req_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable({addr_q, w0_q, w1_q, two_q, rd_q}));

endmodule

// File: tb/ctl3w_master_test.sv
module ctl3w_master_test;

  localparam int L  = 2;
  localparam int H  = 3;
  localparam int S  = 2;
  localparam int HD = 2;
  localparam int HA = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] dev_addr = '0;
  logic [1:0] reg_sel = '0;
  logic       two_bytes = 1'b0;
  logic       read_en = 1'b0;
  logic [7:0] wdata0 = '0;
  logic [7:0] wdata1 = '0;
  logic       sdat_i = 1'b0;
  logic       busy, done, sclk_o, sclk_oe, sdat_o, sdat_oe, smode_o, smode_oe;
  logic [7:0] rdata0, rdata1;

  always #4 clk = ~clk;   // 125 MHz

  ctl3w_master #(
    .LOW_CYC(L), .HIGH_CYC(H), .SETUP_CYC(S), .HOLD_CYC(HD), .HALT_CYC(HA)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr), .reg_sel(reg_sel),
    .two_bytes(two_bytes), .read_en(read_en), .wdata0(wdata0), .wdata1(wdata1),
    .busy(busy), .done(done), .rdata0(rdata0), .rdata1(rdata1),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
    .sdat_i(sdat_i), .smode_o(smode_o), .smode_oe(smode_oe)
  );

  typedef struct {
    logic [7:0] addr;
    bit         two;
    bit         rd;
    logic [7:0] b0;
    logic [7:0] b1;
    int         cyc;
    int         falls;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ---------------- monitor: bus observer, codec model, scoreboard ----------------
  int   cyc = 0, falls = 0, rises = 0, rdk = 0;
  bit   line_bits [0:31];
  bit   psclk = 1'b1, pdat = 1'b1, pdoe = 1'b0;
  bit   stab_bad = 1'b0, mode_bad = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        cyc++;
        if (!(smode_oe && smode_o)) mode_bad = 1'b1;
        if (psclk && sclk_o && pdoe && sdat_oe && (sdat_o !== pdat)) stab_bad = 1'b1;
        if (psclk && !sclk_o) begin
          falls++;
          if (!sdat_oe && exp_q.size() > 0) begin
            // codec answer: falling edge 8 of the data phase is the halt
            if (rdk < 8) sdat_i = exp_q[0].b0[rdk];
            else if (rdk > 8 && rdk < 17) sdat_i = exp_q[0].b1[rdk - 9];
            rdk++;
          end
        end
        if (!psclk && sclk_o) begin
          if (rises < 32) line_bits[rises] = sdat_oe ? sdat_o : sdat_i;
          rises++;
        end
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "done without request", 1, 0);
        end else begin
          exp_t e;
          logic [7:0] a, d0, d1;
          e = exp_q.pop_front();
          for (int i = 0; i < 8; i++) begin
            a[i]  = line_bits[i];
            d0[i] = line_bits[8 + i];
            d1[i] = line_bits[17 + i];
          end
          check(cyc == e.cyc, "R7", "busy cycles", cyc, e.cyc);
          check(falls == e.falls, "R6", "falling clock edges", falls, e.falls);
          check(a == e.addr, "R3", "address byte", a, e.addr);
          if (!e.rd) begin
            check(d0 == e.b0, "R4", "first written byte", d0, e.b0);
            if (e.two) check(d1 == e.b1, "R4", "second written byte after halt", d1, e.b1);
          end else begin
            check(rdata0 == e.b0, "R5", "rdata0", rdata0, e.b0);
            check(rdata1 == (e.two ? e.b1 : 8'h00), "R10", "rdata1",
                  rdata1, e.two ? e.b1 : 8'h00);
          end
          check(!sclk_oe && !sdat_oe && !smode_oe, "R8", "lines released at done",
                {sclk_oe, sdat_oe, smode_oe}, 0);
          check(!stab_bad, "R4", "data stable while clock high", stab_bad, 0);
          check(!mode_bad, "R2", "mode line driven high while busy", mode_bad, 0);
        end
        cyc = 0; falls = 0; rises = 0; rdk = 0;
        stab_bad = 1'b0; mode_bad = 1'b0;
      end
      psclk = sclk_o;
      pdat  = sdat_o;
      pdoe  = sdat_oe;
    end
  end

  // ---------------- driver ----------------
  task automatic run_txn(input logic [5:0] dev, input logic [1:0] sel, input bit two,
                         input bit rd, input logic [7:0] b0, input logic [7:0] b1,
                         input bit poke);
    exp_t e;
    int   nb;
    nb      = two ? 3 : 2;
    e.addr  = {dev, sel};
    e.two   = two;
    e.rd    = rd;
    e.b0    = b0;
    e.b1    = b1;
    e.cyc   = 1 + nb * (S + 8 * (L + H) + HD) + (two ? HA : 0);
    e.falls = 8 * nb + (two ? 1 : 0);
    exp_q.push_back(e);
    @(negedge clk);
    dev_addr = dev; reg_sel = sel; two_bytes = two; read_en = rd;
    wdata0 = b0; wdata1 = b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && sclk_oe && sdat_oe && smode_oe && sclk_o && sdat_o && smode_o,
          "R2", "first busy cycle lines",
          {busy, sclk_oe, sdat_oe, smode_oe, sclk_o, sdat_o, smode_o}, 7'h7f);
    check(rdata0 == 8'h00 && rdata1 == 8'h00, "R10", "read bytes cleared at accept",
          {rdata0, rdata1}, 0);
    if (poke) begin
      // R9: inverted request while busy must not be taken
      repeat (30) @(negedge clk);
      dev_addr = ~dev; reg_sel = ~sel; two_bytes = ~two; read_en = ~rd;
      wdata0 = ~b0; wdata1 = ~b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(!done, "R8", "done lasts one cycle", done, 0);
    check(!busy, "R9", "no transaction after ignored start", busy, 0);
  endtask

  // ---------------- main sequence ----------------
  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !sclk_oe && !sdat_oe && !smode_oe, "R1", "state in reset",
          {busy, done, sclk_oe, sdat_oe, smode_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !sclk_oe && !sdat_oe && !smode_oe, "R1", "idle after reset",
          {busy, done, sclk_oe, sdat_oe, smode_oe}, 0);

    run_txn(6'h05, 2'b00, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b0);  // write, one byte
    run_txn(6'h3F, 2'b11, 1'b1, 1'b0, 8'h3C, 8'h81, 1'b0);  // write, two bytes
    run_txn(6'h2A, 2'b01, 1'b0, 1'b1, 8'hD2, 8'h77, 1'b0);  // read, one byte
    run_txn(6'h11, 2'b10, 1'b1, 1'b1, 8'h6B, 8'hE4, 1'b0);  // read, two bytes
    run_txn(6'h0C, 2'b01, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1);  // write with ignored start
    run_txn(6'h30, 2'b00, 1'b1, 1'b1, 8'h01, 8'h80, 1'b1);  // read with ignored start

    repeat (4) @(negedge clk);
    check(!busy && !sclk_oe && !sdat_oe && !smode_oe && exp_q.size() == 0, "R1",
          "idle at end", {busy, sclk_oe, sdat_oe, smode_oe}, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule